// File: doc/BRIEF.md
# Packed Configuration Stream Sequencer

This block turns a byte-packed configuration image into 16-bit register writes on two PHY register ports. It reads the image one byte at a time from a ROM-like read port that returns data one cycle after the request. A pulse on the start input makes the block check a 24-byte header, read an entry count, and then walk that many variable-length entries.

Each entry is a 32-bit opcode/index word followed by a payload. A single write goes to PHY 0, to PHY 1, or to both. A range entry writes a burst of consecutive 16-bit words to both PHYs. A wait entry stalls the walk until the chosen PHY signals that training has finished. A bad magic value, an unknown opcode or a training failure ends the run with an error code. A run that reaches its last entry ends with a one-cycle done pulse.

Top module: `cfg_stream_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, err_code_o, rd_en_o and both write enables are 0.
- R2: The first 8 stream bytes must form the value 0x4452444445415448. If they do not, the run ends with err_o=1 and err_code_o=1, and no PHY write takes place.
- R3: Stream bytes are read from address 0 upward, and each multi-byte field is assembled little-endian. Bytes 8..19 (type, rank, width, frequency, reserved) are skipped. Bytes 20..23 hold the entry count, and the first entry starts at byte 24.
- R4: An entry word holds the opcode in bits 31:24 and the index in bits 23:0, and it is followed by one 16-bit value. Opcode 0 writes only PHY 0, opcode 1 only PHY 1, and opcode 2 both. The write goes to byte offset index*2.
- R5: Opcode 3 is followed by a 32-bit count N and N 16-bit values. Value j is written to offset index*2+2*j in both PHYs, in order. The next entry starts 8+2*N bytes after the entry start, and N=0 produces no write.
- R6: Opcode 4 (PHY 0) and opcode 5 (PHY 1) consume a 6-byte entry and hold the walk until trn_done_i of that PHY is 1. If trn_fail_i of that PHY is 1, the run ends with err_code_o=3.
- R7: An opcode above 5 ends the run with err_code_o=2, and no later entry is executed.
- R8: After the last counted entry, done_o is 1 for exactly one cycle, in the same cycle that busy_o falls. A count of 0 gives done with no writes.
- R9: A start pulse while busy_o is 1 has no effect on the running sequence.
- R10: A new start clears err_o and err_code_o. rd_en_o is only ever 1 while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle successful-completion pulse |
| err_o | output | 1 | Run ended with an error (held until next start) |
| err_code_o | output | 2 | 1 bad magic, 2 unknown opcode, 3 training failure |
| rd_en_o | output | 1 | Stream byte read request |
| rd_addr_o | output | STREAM_AW | Stream byte address |
| rd_data_i | input | 8 | Stream byte, valid the cycle after the request |
| trn_done_i | input | 2 | Training finished, one bit per PHY |
| trn_fail_i | input | 2 | Training failed, one bit per PHY |
| p0_we_o | output | 1 | PHY 0 write strobe |
| p0_addr_o | output | PHY_AW | PHY 0 byte offset |
| p0_data_o | output | 16 | PHY 0 write data |
| p1_we_o | output | 1 | PHY 1 write strobe |
| p1_addr_o | output | PHY_AW | PHY 1 byte offset |
| p1_data_o | output | 16 | PHY 1 write data |

## Verification
The hardest situation to reach is a wait entry that stays blocked while other traffic arrives. To get there, the bench holds the training-done inputs low for many cycles. During that window it confirms that busy stays high and no write appears, and it sends a second start pulse. It then releases training-done and confirms that the rest of the sequence completes exactly once. The training-failure and bad-opcode cases are placed after a valid write, so the bench can see that the first write happens and that nothing after it does. Random streams mix all write opcodes with range counts from 0 to 4, so the byte alignment after variable-length entries is exercised in many combinations.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
   localparam logic [63:0] HDR_MAGIC = 64'h4452444445415448;
   localparam int unsigned HDR_SKIP  = 12;

   localparam logic [7:0] OP_WR0   = 8'd0;
   localparam logic [7:0] OP_WR1   = 8'd1;
   localparam logic [7:0] OP_WRB   = 8'd2;
   localparam logic [7:0] OP_RANGE = 8'd3;
   localparam logic [7:0] OP_WAIT0 = 8'd4;
   localparam logic [7:0] OP_WAIT1 = 8'd5;

   localparam logic [1:0] ERR_NONE  = 2'd0;
   localparam logic [1:0] ERR_MAGIC = 2'd1;
   localparam logic [1:0] ERR_OPC   = 2'd2;
   localparam logic [1:0] ERR_TRAIN = 2'd3;

   typedef enum logic [3:0] {
      S_IDLE, S_MAGIC, S_SKIP, S_COUNT, S_HEAD,
      S_DATA, S_RLEN, S_RDAT, S_WAIT, S_NEXT
   } seq_state_t;
endpackage

// File: rtl/cfg_byte_fetch.sv
module cfg_byte_fetch #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned MAX_BYTES = 8,
   parameter int unsigned LEN_W     = 4,
   localparam int unsigned VAL_W    = 8 * MAX_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              skip,
   input  logic              req,
   input  logic [LEN_W-1:0]  len,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   output logic [VAL_W-1:0]  val,
   output logic              vld
);
   logic             active, pend;
   logic [LEN_W-1:0] issued, got, need;
   logic [ADDR_W-1:0] ptr;

   if (LEN_W < $clog2(MAX_BYTES + 1)) begin : g_len_chk
      $error("cfg_byte_fetch: LEN_W too small for MAX_BYTES");
   end

   assign rd_en   = active && (issued < need);
   assign rd_addr = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         pend   <= 1'b0;
         issued <= '0;
         got    <= '0;
         need   <= '0;
         ptr    <= '0;
         val    <= '0;
         vld    <= 1'b0;
      end else begin
         vld  <= 1'b0;
         pend <= rd_en;
         if (clr)
            ptr <= '0;
         else if (skip)
            ptr <= ptr + ADDR_W'(len);
         if (req && !active) begin
            active <= 1'b1;
            issued <= '0;
            got    <= '0;
            need   <= len;
            val    <= '0;
         end
         if (rd_en) begin
            ptr    <= ptr + 1'b1;
            issued <= issued + 1'b1;
         end
         if (pend) begin
            val[8*int'(got) +: 8] <= rd_data;
            got <= got + 1'b1;
            if (got == need - 1'b1) begin
               active <= 1'b0;
               vld    <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cfg_phy_wport.sv
module cfg_phy_wport #(
   parameter int unsigned ADDR_W = 25,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              we_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_o   <= 1'b0;
         addr_o <= '0;
         data_o <= '0;
      end else begin
         we_o <= en;
         if (en) begin
            addr_o <= addr;
            data_o <= data;
         end
      end
   end
endmodule

// File: rtl/cfg_stream_seq.sv
module cfg_stream_seq
   import cfg_seq_pkg::*;
#(
   parameter int unsigned STREAM_AW = 16,
   parameter int unsigned PHY_AW    = 25,
   parameter int unsigned NUM_PHY   = 2,
   localparam int unsigned WORD_W   = 16,
   localparam int unsigned LEN_W    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 err_o,
   output logic [1:0]           err_code_o,
   output logic                 rd_en_o,
   output logic [STREAM_AW-1:0] rd_addr_o,
   input  logic [7:0]           rd_data_i,
   input  logic [1:0]           trn_done_i,
   input  logic [1:0]           trn_fail_i,
   output logic                 p0_we_o,
   output logic [PHY_AW-1:0]    p0_addr_o,
   output logic [WORD_W-1:0]    p0_data_o,
   output logic                 p1_we_o,
   output logic [PHY_AW-1:0]    p1_addr_o,
   output logic [WORD_W-1:0]    p1_data_o
);
   if (NUM_PHY != 2) begin : g_phy_chk
      $error("cfg_stream_seq: exactly two PHY ports are supported");
   end
   if (PHY_AW < 2 || PHY_AW > 32) begin : g_aw_chk
      $error("cfg_stream_seq: PHY_AW must be within 2..32");
   end

   seq_state_t state;
   logic             f_clr, f_skip, f_req, f_vld;
   logic [LEN_W-1:0] f_len;
   logic [63:0]      f_val;
   logic [31:0]      remain, rcnt, ridx;
   logic [7:0]       op;
   logic [23:0]      idx;
   logic             done_q, err_q;
   logic [1:0]       code_q;
   logic [NUM_PHY-1:0] wr_en;
   logic [31:0]      off_full;
   logic [PHY_AW-1:0] wr_off;
   logic [WORD_W-1:0] wr_val;
   logic             wait_sel;

   cfg_byte_fetch #(.ADDR_W(STREAM_AW), .MAX_BYTES(8), .LEN_W(LEN_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .clr(f_clr), .skip(f_skip), .req(f_req),
      .len(f_len), .rd_en(rd_en_o), .rd_addr(rd_addr_o), .rd_data(rd_data_i),
      .val(f_val), .vld(f_vld)
   );

   // offset of the current write: entry base plus burst position
   always_comb begin
      wr_en    = '0;
      off_full = {7'd0, idx, 1'b0};
      if (state == S_RDAT)
         off_full = {7'd0, idx, 1'b0} + {ridx[30:0], 1'b0};
      wr_off = off_full[PHY_AW-1:0];
      wr_val = f_val[WORD_W-1:0];
      if (f_vld && state == S_DATA && op <= OP_WRB) begin
         wr_en[0] = (op != OP_WR1);
         wr_en[1] = (op != OP_WR0);
      end
      if (f_vld && state == S_RDAT)
         wr_en = '1;
   end

   logic              pw_we   [NUM_PHY];
   logic [PHY_AW-1:0] pw_addr [NUM_PHY];
   logic [WORD_W-1:0] pw_data [NUM_PHY];

   for (genvar g = 0; g < NUM_PHY; g++) begin : g_port
      cfg_phy_wport #(.ADDR_W(PHY_AW), .DATA_W(WORD_W)) u_wport (
         .clk(clk), .rst_n(rst_n), .en(wr_en[g]), .addr(wr_off), .data(wr_val),
         .we_o(pw_we[g]), .addr_o(pw_addr[g]), .data_o(pw_data[g])
      );
   end

   assign p0_we_o   = pw_we[0];
   assign p0_addr_o = pw_addr[0];
   assign p0_data_o = pw_data[0];
   assign p1_we_o   = pw_we[1];
   assign p1_addr_o = pw_addr[1];
   assign p1_data_o = pw_data[1];

   assign wait_sel   = (op == OP_WAIT1);
   assign busy_o     = (state != S_IDLE);
   assign done_o     = done_q;
   assign err_o      = err_q;
   assign err_code_o = code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         f_clr  <= 1'b0;
         f_skip <= 1'b0;
         f_req  <= 1'b0;
         f_len  <= '0;
         remain <= '0;
         rcnt   <= '0;
         ridx   <= '0;
         op     <= '0;
         idx    <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         code_q <= ERR_NONE;
      end else begin
         f_clr  <= 1'b0;
         f_skip <= 1'b0;
         f_req  <= 1'b0;
         done_q <= 1'b0;
         unique case (state)
            S_IDLE: if (start_i) begin
               err_q  <= 1'b0;
               code_q <= ERR_NONE;
               f_clr  <= 1'b1;
               f_req  <= 1'b1;
               f_len  <= LEN_W'(8);
               state  <= S_MAGIC;
            end
            S_MAGIC: if (f_vld) begin
               if (f_val != HDR_MAGIC) begin
                  err_q  <= 1'b1;
                  code_q <= ERR_MAGIC;
                  state  <= S_IDLE;
               end else begin
                  f_skip <= 1'b1;
                  f_len  <= LEN_W'(HDR_SKIP);
                  state  <= S_SKIP;
               end
            end
            S_SKIP: begin
               f_req <= 1'b1;
               f_len <= LEN_W'(4);
               state <= S_COUNT;
            end
            S_COUNT: if (f_vld) begin
               remain <= f_val[31:0];
               if (f_val[31:0] == 32'd0) begin
                  done_q <= 1'b1;
                  state  <= S_IDLE;
               end else begin
                  f_req <= 1'b1;
                  f_len <= LEN_W'(4);
                  state <= S_HEAD;
               end
            end
            S_HEAD: if (f_vld) begin
               op  <= f_val[31:24];
               idx <= f_val[23:0];
               if (f_val[31:24] > OP_WAIT1) begin
                  err_q  <= 1'b1;
                  code_q <= ERR_OPC;
                  state  <= S_IDLE;
               end else if (f_val[31:24] == OP_RANGE) begin
                  f_req <= 1'b1;
                  f_len <= LEN_W'(4);
                  state <= S_RLEN;
               end else begin
                  f_req <= 1'b1;
                  f_len <= LEN_W'(2);
                  state <= S_DATA;
               end
            end
            S_DATA: if (f_vld) begin
               if (op >= OP_WAIT0) state <= S_WAIT;
               else                state <= S_NEXT;
            end
            S_RLEN: if (f_vld) begin
               rcnt <= f_val[31:0];
               ridx <= '0;
               if (f_val[31:0] == 32'd0) begin
                  state <= S_NEXT;
               end else begin
                  f_req <= 1'b1;
                  f_len <= LEN_W'(2);
                  state <= S_RDAT;
               end
            end
            S_RDAT: if (f_vld) begin
               ridx <= ridx + 1'b1;
               if (ridx + 1'b1 == rcnt) begin
                  state <= S_NEXT;
               end else begin
                  f_req <= 1'b1;
                  f_len <= LEN_W'(2);
               end
            end
            S_WAIT: begin
               if (trn_fail_i[wait_sel]) begin
                  err_q  <= 1'b1;
                  code_q <= ERR_TRAIN;
                  state  <= S_IDLE;
               end else if (trn_done_i[wait_sel]) begin
                  state <= S_NEXT;
               end
            end
            S_NEXT: begin
               remain <= remain - 1'b1;
               if (remain == 32'd1) begin
                  done_q <= 1'b1;
                  state  <= S_IDLE;
               end else begin
                  f_req <= 1'b1;
                  f_len <= LEN_W'(4);
                  state <= S_HEAD;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cfg_stream_seq_chk.sv
module cfg_stream_seq_chk #(
   parameter int unsigned STREAM_AW = 16,
   parameter int unsigned PHY_AW    = 25
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 busy_o,
   input logic                 done_o,
   input logic                 err_o,
   input logic                 rd_en_o,
   input logic                 p0_we_o,
   input logic [PHY_AW-1:0]    p0_addr_o,
   input logic                 p1_we_o,
   input logic [PHY_AW-1:0]    p1_addr_o
);
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !err_o));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_end_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (done_o || err_o));

   p_write_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_we_o || p1_we_o) |-> busy_o);

   p_even_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_we_o |-> !p0_addr_o[0]) and (p1_we_o |-> !p1_addr_o[0]));

   p_read_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |-> busy_o);

   p_err_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> (!busy_o && !rd_en_o));
endmodule

bind cfg_stream_seq cfg_stream_seq_chk #(.STREAM_AW(STREAM_AW), .PHY_AW(PHY_AW)) u_chk (.*);

// File: tb/cfg_stream_seq_test.sv
module cfg_stream_seq_test;
   localparam int AW = 16;
   localparam int PAW = 25;
   localparam int MAXW = 512;

   logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
   logic busy_o, done_o, err_o, rd_en_o, p0_we_o, p1_we_o;
   logic [1:0] err_code_o, trn_done_i, trn_fail_i;
   logic [AW-1:0] rd_addr_o;
   logic [7:0] rd_data_i;
   logic [PAW-1:0] p0_addr_o, p1_addr_o;
   logic [15:0] p0_data_o, p1_data_o;

   always #10 clk = ~clk;

   cfg_stream_seq #(.STREAM_AW(AW), .PHY_AW(PAW)) uut (.*);

   logic [7:0] mem [0:4095];
   always_ff @(posedge clk) if (rd_en_o) rd_data_i <= mem[rd_addr_o[11:0]];

   int checks = 0, errors = 0, wp = 0;
   logic [PAW-1:0] xa [2][MAXW]; logic [15:0] xd [2][MAXW]; int xn [2];
   logic [PAW-1:0] ga [2][MAXW]; logic [15:0] gd [2][MAXW]; int gn [2];

   always @(negedge clk) begin
      if (p0_we_o && gn[0] < MAXW) begin ga[0][gn[0]] = p0_addr_o; gd[0][gn[0]] = p0_data_o; gn[0]++; end
      if (p1_we_o && gn[1] < MAXW) begin ga[1][gn[1]] = p1_addr_o; gd[1][gn[1]] = p1_data_o; gn[1]++; end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
         errors++; checks++;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin errors++; $display("FAIL %s: actual %0h expected %0h", req, act, exp); end
   endtask

   task automatic b8(input logic [7:0] v); mem[wp] = v; wp++; endtask
   task automatic b16(input logic [15:0] v); b8(v[7:0]); b8(v[15:8]); endtask
   task automatic b32(input logic [31:0] v); b16(v[15:0]); b16(v[31:16]); endtask

   task automatic hdr(input logic [31:0] cnt, input logic [63:0] magic);
      wp = 0; xn[0] = 0; xn[1] = 0; gn[0] = 0; gn[1] = 0;
      b32(magic[31:0]); b32(magic[63:32]);
      for (int i = 0; i < 12; i++) b8(8'($urandom));
      b32(cnt);
   endtask

   function automatic logic [PAW-1:0] offs(input logic [23:0] idx, input int j);
      logic [31:0] t = {7'd0, idx, 1'b0} + 32'(2 * j);
      return t[PAW-1:0];
   endfunction

   task automatic expw(input int p, input logic [PAW-1:0] a, input logic [15:0] d);
      xa[p][xn[p]] = a; xd[p][xn[p]] = d; xn[p]++;
   endtask

   task automatic e_single(input logic [7:0] op, input logic [23:0] idx, input logic [15:0] d);
      b32({op, idx}); b16(d);
      if (op == 0 || op == 2) expw(0, offs(idx, 0), d);
      if (op == 1 || op == 2) expw(1, offs(idx, 0), d);
   endtask

   task automatic e_range(input logic [23:0] idx, input int n);
      b32({8'd3, idx}); b32(32'(n));
      for (int j = 0; j < n; j++) begin
         logic [15:0] d = 16'($urandom);
         b16(d); expw(0, offs(idx, j), d); expw(1, offs(idx, j), d);
      end
   endtask

   task automatic run(input string req, input logic [1:0] exp_code);
      int t = 0;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      while (busy_o && t < 5000) begin @(negedge clk); t++; end
      chk(!busy_o, req, busy_o, 0);
      chk(done_o == (exp_code == 0), req, done_o, exp_code == 0);
      chk(err_code_o == exp_code && err_o == (exp_code != 0), req, err_code_o, exp_code);
   endtask

   task automatic cmp(input string req);
      for (int p = 0; p < 2; p++) begin
         chk(gn[p] == xn[p], req, gn[p], xn[p]);
         for (int i = 0; i < xn[p] && i < gn[p]; i++) begin
            chk(ga[p][i] == xa[p][i], req, ga[p][i], xa[p][i]);
            chk(gd[p][i] == xd[p][i], req, gd[p][i], xd[p][i]);
         end
      end
   endtask

   localparam logic [63:0] MAGIC = 64'h4452444445415448;

   initial begin
      void'($urandom(32'd20250426));
      trn_done_i = 2'b11; trn_fail_i = 2'b00;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({busy_o, done_o, err_o, err_code_o, rd_en_o, p0_we_o, p1_we_o} == 0, "R1", busy_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !rd_en_o, "R1", rd_en_o, 0);

      // R3/R4 directed single writes, little-endian fields
      hdr(3, MAGIC);
      e_single(0, 24'h000123, 16'hA5C3);
      e_single(1, 24'hABCDEF, 16'h1234);
      e_single(2, 24'h0D0031, 16'hBEEF);
      run("R4", 0); cmp("R4");
      chk(xa[1][0] == 25'h157_9BDE, "R3", xa[1][0], 25'h1579BDE);

      // R5 range then single; range with N=0 then single
      hdr(3, MAGIC);
      e_range(24'h000200, 3);
      e_single(0, 24'h000010, 16'h0F0F);
      e_range(24'h000300, 0);
      run("R5", 0); cmp("R5");
      hdr(2, MAGIC);
      e_range(24'h000400, 0);
      e_single(2, 24'h000011, 16'h7777);
      run("R5", 0); cmp("R5");

      // R8 zero count
      hdr(0, MAGIC);
      run("R8", 0); cmp("R8");

      // R2 bad magic
      hdr(1, MAGIC ^ 64'h1);
      e_single(2, 24'h1, 16'h1);
      xn[0] = 0; xn[1] = 0;
      run("R2", 2'd1); cmp("R2");

      // R10 err cleared by next good run
      hdr(1, MAGIC);
      e_single(0, 24'h5, 16'h5);
      run("R10", 0); cmp("R10");

      // R7 unsupported opcode after a good entry
      hdr(3, MAGIC);
      e_single(0, 24'h20, 16'h2020);
      b32({8'd6, 24'h30}); b16(16'h3030);
      b32({8'd0, 24'h40}); b16(16'h4040);
      run("R7", 2'd2); cmp("R7");

      // R6/R9 blocking wait with a start pulse while blocked
      hdr(3, MAGIC);
      e_single(0, 24'h50, 16'h5050);
      e_single(4, 24'h0, 16'hFFFF);
      e_single(1, 24'h60, 16'h6060);
      trn_done_i = 2'b10;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      repeat (60) @(negedge clk);
      chk(busy_o, "R6", busy_o, 1);
      chk(gn[0] == 1 && gn[1] == 0, "R6", gn[1], 0);
      start_i = 1'b1; @(negedge clk) start_i = 1'b0;   // R9 ignored start
      repeat (5) @(negedge clk);
      trn_done_i = 2'b11;
      begin
         int t = 0;
         while (busy_o && t < 5000) begin @(negedge clk); t++; end
      end
      chk(!busy_o && done_o && !err_o, "R6", done_o, 1);
      repeat (20) @(negedge clk);
      chk(!busy_o, "R9", busy_o, 0);
      cmp("R9");

      // R6 training failure on PHY 1
      hdr(3, MAGIC);
      e_single(2, 24'h70, 16'h7070);
      e_single(5, 24'h0, 16'h0);
      b32({8'd0, 24'h80}); b16(16'h8080);
      trn_done_i = 2'b00; trn_fail_i = 2'b10;
      run("R6", 2'd3); cmp("R6");
      trn_done_i = 2'b11; trn_fail_i = 2'b00;

      // R3/R4/R5 random streams
      for (int r = 0; r < 20; r++) begin
         int n = 1 + $urandom_range(0, 7);
         hdr(32'(n), MAGIC);
         for (int e = 0; e < n; e++) begin
            int op = $urandom_range(0, 5);
            logic [23:0] idx = 24'($urandom);
            if (op == 3) e_range(idx, $urandom_range(0, 4));
            else e_single(8'(op), idx, 16'($urandom));
         end
         run("R5", 0); cmp("R4");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule